// File: doc/BRIEF.md
# Shift-Register SAT Clause Evaluator

This block tracks the truth status of a bank of CNF clauses while a search engine assigns and retracts variables one at a time. Each clause carries a one-hot position token of width 2K+1, where K is the longest clause allowed. The token starts at the centre. A literal made true moves the token one place right, toward bit 0. A literal made false moves it one place left, toward the top bit. A variable that does not occur in the clause leaves it in place. Retracting an assignment applies the reverse move, so backtracking restores the exact earlier state.

The per-variable effect on each clause is not wired as matching logic. It sits in a small effect store with one row per variable, and the search engine fills it before solving. Row bits [2c+1:2c] hold the 2-bit code for clause c. A new problem instance therefore needs only fresh rows. A clause's literal count is kept up to date from the codes as rows are written.

A two-state controller sequences the block. LOAD is entered from reset and through the RELOAD transition, which is any row write. In LOAD every status flag reads 0. RUN is entered through the START transition, which is the first command accepted while in LOAD. In RUN the flags show the OR of the clause conflicts, the OR of the clause unit conditions, and the AND of the clause satisfied conditions.

Top module: `sat_clause_eval`

## Requirements
- R1: Effect code 01 marks a positive literal, 10 a negative literal, and 00 or 11 absence. A positive literal is made true by value 1 and false by value 0; a negative literal is the reverse.
- R2: A command on a variable whose code is absent from a clause leaves that clause's status unchanged.
- R3: An unassign command carrying the same variable and value as an earlier assign restores every clause's status to what it was before that assign.
- R4: A row write (RELOAD) recentres every clause token, drops all assignments and enters LOAD, so all flags read 0 the next cycle. A command presented in the same cycle as a write is ignored.
- R5: In RUN, conflict_o is 1 when some clause with L≥1 literals has all L literals false.
- R6: In RUN, unit_o is 1 when some clause with L≥1 literals has no true literal, L-1 false literals and exactly one unassigned literal.
- R7: In RUN, all_sat_o is 1 when every clause has at least one true literal, or no literals at all.
- R8: A clause with no literals never raises a conflict or unit condition.
- R9: Flags reflect all commands accepted up to and including the previous clock edge. The first command in LOAD is applied and causes START.
- R10: After reset the effect store holds all zeros, the controller is in LOAD and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ld_we | input | 1 | Effect row write strobe |
| ld_var | input | VW | Variable whose row is written |
| ld_row | input | 2*NCLAUSES | Effect codes, clause c at bits [2c+1:2c] |
| cmd_valid | input | 1 | Assign or unassign command strobe |
| cmd_unassign | input | 1 | 1 = retract, 0 = assign |
| cmd_var | input | VW | Variable index of the command |
| cmd_value | input | 1 | Boolean value assigned or retracted |
| conflict_o | output | 1 | Some clause fully falsified |
| unit_o | output | 1 | Some clause has one open literal left |
| all_sat_o | output | 1 | Every clause satisfied |

## Verification
The hardest situations to reach are the ones that depend on history. Examples are a clause becoming unit only after true literals were retracted, or a clause becoming satisfied only after other assignments were undone in a different order.

The stimulus reaches these states through a random walk over legal assign and retract commands on several random instances. Directed sequences are added that retract out of order, and one that writes a row in the same cycle as a command. A behavioural model recomputes every clause's status from the current assignment and is compared with the flags on every cycle.

// File: rtl/sat_eval_pkg.sv
package sat_eval_pkg;
    typedef enum logic [1:0] {
        EFF_NONE = 2'b00,
        EFF_POS  = 2'b01,
        EFF_NEG  = 2'b10,
        EFF_RSVD = 2'b11
    } effect_e;

    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic logic lit_present(input logic [1:0] code);
        return (code == EFF_POS) || (code == EFF_NEG);
    endfunction
endpackage

// File: rtl/effect_store.sv
module effect_store #(
    parameter int NVARS    = 16,
    parameter int NCLAUSES = 8,
    localparam int VW      = $clog2(NVARS),
    localparam int RW      = 2 * NCLAUSES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [VW-1:0] wr_addr,
    input  logic [RW-1:0] wr_row,
    input  logic [VW-1:0] rd_addr,
    output logic [RW-1:0] rd_row,
    output logic [RW-1:0] old_row
);
    logic [RW-1:0] rows_q [NVARS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < NVARS; v++) rows_q[v] <= '0;
        end else if (wr_en) begin
            rows_q[wr_addr] <= wr_row;
        end
    end

    assign rd_row  = rows_q[rd_addr];
    assign old_row = rows_q[wr_addr];

    // R4: a written row is visible at the read port on the next cycle
    assert_row_written_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr == wr_addr) |=> ($stable(rd_addr) -> rd_row == $past(wr_row)));
endmodule

// File: rtl/clause_cell.sv
module clause_cell
    import sat_eval_pkg::*;
#(
    parameter int KMAX = 3,
    parameter int LW   = 5,
    localparam int TW  = 2 * KMAX + 1,
    localparam int SW  = $clog2(KMAX + 2)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       recentre,
    input  logic [1:0] old_code,
    input  logic [1:0] new_code,
    input  logic       step_en,
    input  logic       step_unassign,
    input  logic [1:0] code,
    input  logic       value,
    output logic       conflict_o,
    output logic       unit_o,
    output logic       satisfied_o
);
    localparam logic [TW-1:0] CENTRE = TW'(1) << KMAX;

    logic [TW-1:0] token_q;
    logic [SW-1:0] satcnt_q;
    logic [LW-1:0] len_q;
    logic hit_sat, hit_fals, move_right, move_left, conf_hit, unit_hit, active;

    assign hit_sat  = (code == EFF_POS && value) || (code == EFF_NEG && !value);
    assign hit_fals = (code == EFF_POS && !value) || (code == EFF_NEG && value);
    assign move_right = step_en && ((hit_sat && !step_unassign) || (hit_fals && step_unassign));
    assign move_left  = step_en && ((hit_fals && !step_unassign) || (hit_sat && step_unassign));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            token_q  <= CENTRE;
            satcnt_q <= '0;
            len_q    <= '0;
        end else if (recentre) begin
            token_q  <= CENTRE;
            satcnt_q <= '0;
            len_q    <= len_q - LW'(lit_present(old_code)) + LW'(lit_present(new_code));
        end else begin
            if (move_right && !token_q[0])         token_q <= token_q >> 1;
            else if (move_left && !token_q[TW-1])  token_q <= token_q << 1;
            if (step_en && hit_sat && !step_unassign && satcnt_q != SW'(KMAX))
                satcnt_q <= satcnt_q + 1'b1;
            else if (step_en && hit_sat && step_unassign && satcnt_q != '0)
                satcnt_q <= satcnt_q - 1'b1;
        end
    end

    always_comb begin
        conf_hit = 1'b0;
        unit_hit = 1'b0;
        for (int i = 0; i < TW; i++) begin
            if (i == KMAX + int'(len_q))     conf_hit = token_q[i];
            if (i == KMAX + int'(len_q) - 1) unit_hit = token_q[i];
        end
    end

    assign active      = (len_q != '0);
    assign conflict_o  = active && conf_hit;
    assign unit_o      = active && unit_hit && (satcnt_q == '0);
    assign satisfied_o = !active || (satcnt_q != '0);

    assert_token_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(token_q));
    assert_recentre_R4: assert property (@(posedge clk) disable iff (!rst_n)
        recentre |=> (token_q == CENTRE && satcnt_q == '0));
    assert_absent_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!recentre && step_en && !hit_sat && !hit_fals) |=> $stable(token_q) && $stable(satcnt_q));
    assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (len_q == '0) |-> (!conflict_o && !unit_o));
endmodule

// File: rtl/sat_clause_eval.sv
module sat_clause_eval
    import sat_eval_pkg::*;
#(
    parameter int NVARS    = 16,
    parameter int NCLAUSES = 8,
    parameter int KMAX     = 3,
    localparam int VW      = $clog2(NVARS),
    localparam int RW      = 2 * NCLAUSES,
    localparam int LW      = $clog2(NVARS + 1) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [VW-1:0] ld_var,
    input  logic [RW-1:0] ld_row,
    input  logic          cmd_valid,
    input  logic          cmd_unassign,
    input  logic [VW-1:0] cmd_var,
    input  logic          cmd_value,
    output logic          conflict_o,
    output logic          unit_o,
    output logic          all_sat_o
);
    phase_e phase_q, phase_d;
    logic [RW-1:0] rd_row, old_row;
    logic [NCLAUSES-1:0] cl_conf, cl_unit, cl_sat;
    logic step_en;

    assign step_en = cmd_valid && !ld_we;

    effect_store #(.NVARS(NVARS), .NCLAUSES(NCLAUSES)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(ld_we), .wr_addr(ld_var), .wr_row(ld_row),
        .rd_addr(cmd_var), .rd_row(rd_row), .old_row(old_row)
    );

    for (genvar c = 0; c < NCLAUSES; c++) begin : g_clause
        clause_cell #(.KMAX(KMAX), .LW(LW)) u_cell (
            .clk(clk), .rst_n(rst_n), .recentre(ld_we),
            .old_code(old_row[2*c +: 2]), .new_code(ld_row[2*c +: 2]),
            .step_en(step_en), .step_unassign(cmd_unassign),
            .code(rd_row[2*c +: 2]), .value(cmd_value),
            .conflict_o(cl_conf[c]), .unit_o(cl_unit[c]), .satisfied_o(cl_sat[c])
        );
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_LOAD;
        else        phase_q <= phase_d;
    end

    // transitions: START (LOAD -> RUN), RELOAD (RUN -> LOAD)
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOAD: if (ld_we) phase_d = PH_LOAD;
                     else if (cmd_valid) phase_d = PH_RUN;
            PH_RUN:  if (ld_we) phase_d = PH_LOAD;
            default: phase_d = PH_LOAD;
        endcase
    end

    // outputs
    always_comb begin
        conflict_o = 1'b0;
        unit_o     = 1'b0;
        all_sat_o  = 1'b0;
        unique case (phase_q)
            PH_LOAD: ;
            PH_RUN: begin
                conflict_o = |cl_conf;
                unit_o     = |cl_unit;
                all_sat_o  = &cl_sat;
            end
            default: ;
        endcase
    end

    assert_reload_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (!conflict_o && !unit_o && !all_sat_o));
    assert_conf_not_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conflict_o |-> !all_sat_o);
    assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LOAD && cmd_valid && !ld_we) |=> phase_q == PH_RUN);
endmodule

// File: tb/test_sat_clause_eval.sv
module test_sat_clause_eval;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 16;
    localparam int NC = 8;
    localparam int K  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_we = 1'b0;
    logic [3:0] ld_var = '0;
    logic [2*NC-1:0] ld_row = '0;
    logic cmd_valid = 1'b0, cmd_unassign = 1'b0, cmd_value = 1'b0;
    logic [3:0] cmd_var = '0;
    logic conflict_o, unit_o, all_sat_o;

    int checks = 0, failures = 0, cycles = 0;
    bit done = 0;
    string cur_req = "R10";

    int mcode [NV][NC];
    int mval [NV];
    bit mload;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_clause_eval #(.NVARS(NV), .NCLAUSES(NC), .KMAX(K)) i_sat_clause_eval (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_var(ld_var), .ld_row(ld_row),
        .cmd_valid(cmd_valid), .cmd_unassign(cmd_unassign), .cmd_var(cmd_var),
        .cmd_value(cmd_value), .conflict_o(conflict_o), .unit_o(unit_o), .all_sat_o(all_sat_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (%s) t=%0t actual=%b expected=%b", req, cur_req, $time, act, exp);
        end
    endtask

    // behavioural status of the instance from the current assignment
    task automatic compare_model();
        bit e_conf = 0, e_unit = 0, e_all = 1;
        for (int c = 0; c < NC; c++) begin
            int len = 0, nt = 0, nf = 0;
            for (int v = 0; v < NV; v++) begin
                if (mcode[v][c] == 1 || mcode[v][c] == 2) begin
                    len++;
                    if (mval[v] >= 0) begin
                        if ((mcode[v][c] == 1) == (mval[v] == 1)) nt++; else nf++;
                    end
                end
            end
            if (len > 0) begin
                if (nt == 0 && nf == len) e_conf = 1;
                if (nt == 0 && nf == len - 1) e_unit = 1;
                if (nt == 0) e_all = 0;
            end
        end
        if (mload) begin e_conf = 0; e_unit = 0; e_all = 0; end
        check("R5", conflict_o, e_conf);
        check("R6", unit_o, e_unit);
        check("R7", all_sat_o, e_all);
    endtask

    task automatic step(input bit we, input int wv, input logic [2*NC-1:0] row,
                        input bit cv, input bit un, input int cvar, input bit val);
        ld_we = we; ld_var = 4'(wv); ld_row = row;
        cmd_valid = cv; cmd_unassign = un; cmd_var = 4'(cvar); cmd_value = val;
        @(posedge clk);
        if (we) begin
            for (int c = 0; c < NC; c++) mcode[wv][c] = int'(row[2*c +: 2]);
            for (int v = 0; v < NV; v++) mval[v] = -1;
            mload = 1;
        end else if (cv) begin
            mval[cvar] = un ? -1 : int'(val);
            mload = 0;
        end
        @(negedge clk);
        ld_we = 0; cmd_valid = 0;
        compare_model();
    endtask

    task automatic write_instance(input int codes [NV][NC]);
        for (int v = 0; v < NV; v++) begin
            logic [2*NC-1:0] r = '0;
            for (int c = 0; c < NC; c++) r[2*c +: 2] = 2'(codes[v][c]);
            step(1, v, r, 0, 0, 0, 0);
        end
    endtask

    task automatic asg(input int v, input bit val);
        step(0, 0, '0, 1, 0, v, val);
    endtask
    task automatic unasg(input int v, input bit val);
        step(0, 0, '0, 1, 1, v, val);
    endtask

    initial begin
        int codes [NV][NC];
        for (int v = 0; v < NV; v++) begin
            mval[v] = -1;
            for (int c = 0; c < NC; c++) begin mcode[v][c] = 0; codes[v][c] = 0; end
        end
        mload = 1;
        repeat (3) @(negedge clk);
        cur_req = "R10";
        check("R10", conflict_o, 0); check("R10", unit_o, 0); check("R10", all_sat_o, 0);
        rst_n = 1;
        @(negedge clk);
        // R10: empty store, first command starts RUN: every clause empty -> all satisfied (R8, R9)
        cur_req = "R9";
        asg(0, 1);
        check("R8", conflict_o, 0);
        check("R9", all_sat_o, 1);

        // directed instance; code 3 on x6 in c4 counts as absent (R1)
        codes[0][0] = 1; codes[1][0] = 1; codes[2][0] = 2;
        codes[0][1] = 2; codes[3][1] = 1;
        codes[2][2] = 1;
        codes[1][3] = 2; codes[3][3] = 2; codes[4][3] = 1;
        codes[5][4] = 1; codes[6][4] = 3;
        cur_req = "R4";
        write_instance(codes);
        check("R4", all_sat_o, 0);
        cur_req = "R1";
        asg(2, 0);              // single-literal clause c2 falsified
        check("R5", conflict_o, 1);
        cur_req = "R3";
        unasg(2, 0);
        check("R3", conflict_o, 0);
        cur_req = "R6";
        asg(0, 0); asg(1, 0);   // c0 two false of three -> unit
        check("R6", unit_o, 1);
        cur_req = "R2";
        asg(6, 1);              // absent-coded variable: status unchanged
        check("R2", unit_o, 1);
        cur_req = "R5";
        asg(2, 1);              // c0 fully false
        check("R5", conflict_o, 1);
        cur_req = "R3";
        unasg(0, 0);            // out-of-order retract
        check("R3", conflict_o, 0);
        asg(0, 1); asg(3, 1); asg(4, 1); asg(5, 1);
        cur_req = "R7";
        check("R7", all_sat_o, 1);
        cur_req = "R4";
        step(1, 9, '0, 1, 0, 3, 0); // write with simultaneous command
        check("R4", all_sat_o, 0);
        asg(2, 0);
        check("R4", conflict_o, 1);

        // random instances with random legal walks
        for (int inst = 0; inst < 4; inst++) begin
            cur_req = "R1";
            for (int v = 0; v < NV; v++)
                for (int c = 0; c < NC; c++) codes[v][c] = 0;
            for (int c = 0; c < NC; c++) begin
                int n = int'($urandom_range(0, K));
                for (int l = 0; l < n; l++) begin
                    int v = int'($urandom_range(0, NV - 1));
                    if (codes[v][c] == 0) codes[v][c] = int'($urandom_range(1, 2));
                end
                if ($urandom_range(0, 3) == 0) codes[int'($urandom_range(0, NV-1))][c] =
                    (codes[int'($urandom_range(0, NV-1))][c] == 0) ? 3 : codes[0][c];
            end
            write_instance(codes);
            cur_req = "R3";
            for (int s = 0; s < 1500; s++) begin
                int v = int'($urandom_range(0, NV - 1));
                if ($urandom_range(0, 7) == 0) step(0, 0, '0, 0, 0, 0, 0);
                else if (mval[v] < 0) asg(v, 1'($urandom_range(0, 1)));
                else unasg(v, 1'(mval[v]));
            end
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                done = 1;
                checks++; failures++;
                $display("FAIL watchdog (%s) actual=%0d expected<=100000", cur_req, cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end
endmodule